// File: doc/BRIEF.md
# Seconds Counter with Two Alarms

This block is the register-mapped core of a real-time clock. It keeps a 32-bit count of elapsed seconds that advances on a one-second tick input. Software can load the count directly. Two 32-bit alarm values are compared against the count on every tick. A match latches a status bit for that alarm.

Each alarm also has a small configuration register. Its enable bit gates the status bit onto that alarm's interrupt output. Its periodic bits can make the status bit set on every tick instead, taking either the one-second tick or a faster tick input.

Status bits clear when software writes a one to them. Writing a zero to a status bit leaves it alone. The core also holds a calibration word and a configuration word. The configuration word comes out of reset with a non-zero low byte, which marks the clock as not yet set up.

After every accepted write the core stalls the bus for a fixed number of clock cycles while the write settles. It does this by pulling its ready output low.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset the status, both configuration registers, the seconds count, both alarm values and the calibration word read 0. The configuration word reads CONF_INIT (default 0x000000A5, with bits [7:0] non-zero). Both interrupts are low and ready is high.
- R2: The register slots are selected by bus_addr[4:2]. Slot 0 is status, 1 is alarm-1 config, 2 is alarm-2 config, 3 is seconds, 4 is alarm-1 value, 5 is alarm-2 value, 6 is calibration and 7 is configuration word. The config and value registers of alarm n sit at slots n and n+3. Config registers keep bits [2:0] and read zero above them. The other data registers keep all 32 bits.
- R3: Each cycle with tick_sec high adds one to the seconds count, which wraps from 0xFFFFFFFF to 0.
- R4: A write to the seconds slot loads the written value. If a tick arrives in the same cycle, the written value is kept and the tick adds nothing.
- R5: On a tick_sec cycle, if the seconds count before the increment equals an alarm value, status bit 0 (alarm 1) or bit 1 (alarm 2) sets and stays set.
- R6: Config bit 1 enables periodic mode. In this mode the alarm's status bit sets on every tick_sec cycle when config bit 2 is 1, and on every tick_fast cycle when config bit 2 is 0.
- R7: Writing status clears each bit written as 1 and keeps each bit written as 0. A set event in the same cycle as a clear leaves the bit set.
- R8: Each interrupt output is high exactly while its status bit and its config bit 0 are both 1.
- R9: An access is accepted on a cycle with bus_req and bus_ready both high. After an accepted write, bus_ready stays low for SETTLE_CYCLES cycles. A request made during that window is held off until ready returns, and is then performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_sec | input | 1 | One-second tick, one cycle wide |
| tick_fast | input | 1 | Faster periodic tick, one cycle wide |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] pick the register slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed slot |
| bus_ready | output | 1 | High when an access can be accepted |
| irq_alarm1 | output | 1 | Alarm-1 interrupt |
| irq_alarm2 | output | 1 | Alarm-2 interrupt |

## Verification
Two pairs of functions can collide in one cycle, and each collision is forced on purpose. The first pair is a software write of a one to a status bit and a set event for that bit. The bench lines up a fast tick, with periodic mode on, with the very edge that accepts the clear. It expects the bit to read back as 1. The second pair is a seconds load and a seconds tick. The bench raises tick_sec on the accepting edge of a seconds write and expects the written value to read back with no increment.

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm #(
  parameter int          SETTLE_CYCLES = 1250,
  parameter logic [31:0] CONF_INIT     = 32'h0000_00A5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_sec,
  input  logic        tick_fast,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  output logic        irq_alarm1,
  output logic        irq_alarm2
);
  localparam int CW = $clog2(SETTLE_CYCLES + 2);

  logic [CW-1:0] settle_cnt;
  logic [1:0]    status;
  logic [2:0]    irq_cfg [2];
  logic [31:0]   alarm   [2];
  logic [31:0]   seconds, calib, conf;
  logic [1:0]    hit;

  wire       wr   = bus_req && bus_ready && bus_we;
  wire [2:0] slot = bus_addr[4:2];
  wire [1:0] clr  = (wr && slot == 3'd0) ? bus_wdata[1:0] : 2'b00;

  assign bus_ready  = (settle_cnt == '0);
  assign irq_alarm1 = status[0] & irq_cfg[0][0];
  assign irq_alarm2 = status[1] & irq_cfg[1][0];

  always_comb begin
    for (int n = 0; n < 2; n++)
      hit[n] = (tick_sec && seconds == alarm[n]) ||
               (irq_cfg[n][1] && (irq_cfg[n][2] ? tick_sec : tick_fast));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      status     <= '0;
      seconds    <= '0;
      calib      <= '0;
      conf       <= CONF_INIT;
      for (int n = 0; n < 2; n++) begin
        irq_cfg[n] <= '0;
        alarm[n]   <= '0;
      end
    end else begin
      status <= (status & ~clr) | hit;
      if (wr)                   settle_cnt <= CW'(SETTLE_CYCLES);
      else if (settle_cnt != 0) settle_cnt <= settle_cnt - 1'b1;
      if (wr && slot == 3'd3) seconds <= bus_wdata;
      else if (tick_sec)      seconds <= seconds + 32'd1;
      for (int n = 0; n < 2; n++) begin
        if (wr && slot == 3'(1 + n)) irq_cfg[n] <= bus_wdata[2:0];
        if (wr && slot == 3'(4 + n)) alarm[n]   <= bus_wdata;
      end
      if (wr && slot == 3'd6) calib <= bus_wdata;
      if (wr && slot == 3'd7) conf  <= bus_wdata;
    end
  end

  always_comb begin
    case (slot)
      3'd0:    bus_rdata = {30'd0, status};
      3'd1:    bus_rdata = {29'd0, irq_cfg[0]};
      3'd2:    bus_rdata = {29'd0, irq_cfg[1]};
      3'd3:    bus_rdata = seconds;
      3'd4:    bus_rdata = alarm[0];
      3'd5:    bus_rdata = alarm[1];
      3'd6:    bus_rdata = calib;
      default: bus_rdata = conf;
    endcase
  end

  a_r9_write_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (SETTLE_CYCLES > 0) && wr |=> !bus_ready);
  a_r3_tick_increments: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sec && !(wr && slot == 3'd3) |=> seconds == $past(seconds) + 32'd1);
  a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr && slot == 3'd3 |=> seconds == $past(bus_wdata));
  a_r5_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sec && seconds == alarm[0] |=> status[0]);
  a_r7_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr && slot == 3'd0 && !bus_wdata[0] && status[0] |=> status[0]);
  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm2 |-> status[1] && irq_cfg[1][0]);
endmodule

// File: tb/rtc_seconds_alarm_tb.sv
`timescale 1ns/1ps
module rtc_seconds_alarm_tb;
  localparam int SETTLE = 8;

  logic clk = 0, rst_n = 0, tick_sec = 0, tick_fast = 0;
  logic bus_req = 0, bus_we = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_ready, irq_alarm1, irq_alarm2;

  rtc_seconds_alarm #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .tick_fast(tick_fast),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .irq_alarm1(irq_alarm1), .irq_alarm2(irq_alarm2));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] e_v;
  string       t_v;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [4:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus(1'b1, a, d);
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b0, a, 32'd0);
  endtask

  task automatic tsec();
    tick_sec = 1; @(posedge clk); #1; tick_sec = 0;
  endtask

  task automatic tfast();
    tick_fast = 1; @(posedge clk); #1; tick_fast = 0;
  endtask

  task automatic wait_ready();
    while (!bus_ready) begin @(posedge clk); #1; end
  endtask

  always @(negedge clk) begin
    if (bus_req && !bus_we && bus_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual %h expected <none queued>", bus_rdata);
      end else begin
        e_v = exp_q.pop_front();
        t_v = tag_q.pop_front();
        chk(t_v, bus_rdata, e_v);
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    chk("R1 irq1", {31'd0, irq_alarm1}, 0);
    chk("R1 irq2", {31'd0, irq_alarm2}, 0);
    chk("R1 ready", {31'd0, bus_ready}, 1);
    rd(5'h00, 0, "R1 status");
    rd(5'h04, 0, "R1 cfg1");
    rd(5'h08, 0, "R1 cfg2");
    rd(5'h0C, 0, "R1 seconds");
    rd(5'h10, 0, "R1 alarm1");
    rd(5'h14, 0, "R1 alarm2");
    rd(5'h18, 0, "R1 calib");
    rd(5'h1C, 32'h0000_00A5, "R1 conf");

    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, 7, "R2 cfg1 width");
    wr(5'h08, 32'hFFFF_FFF9); rd(5'h08, 1, "R2 cfg2 width");
    wr(5'h04, 0); wr(5'h08, 0);
    wr(5'h10, 32'h1234_5678); rd(5'h10, 32'h1234_5678, "R2 alarm1");
    wr(5'h14, 32'hCAFE_F00D); rd(5'h14, 32'hCAFE_F00D, "R2 alarm2");
    wr(5'h18, 32'h0000_ABCD); rd(5'h18, 32'h0000_ABCD, "R2 calib");
    wr(5'h1C, 32'h0000_2000); rd(5'h1C, 32'h0000_2000, "R2 conf");

    wr(5'h0C, 32'hFFFF_FFFE);
    tsec(); tsec(); tsec();
    rd(5'h0C, 1, "R3 wrap");

    wait_ready();
    tick_sec = 1; wr(5'h0C, 100); tick_sec = 0;
    rd(5'h0C, 100, "R4 write beats tick");

    wr(5'h10, 102); wr(5'h04, 1);
    tsec(); tsec();
    chk("R5 no early match", {31'd0, irq_alarm1}, 0);
    tsec();
    chk("R5 irq1 on match", {31'd0, irq_alarm1}, 1);
    chk("R5 irq2 quiet", {31'd0, irq_alarm2}, 0);
    tsec();
    rd(5'h00, 1, "R5 status latched");

    wr(5'h00, 0);  rd(5'h00, 1, "R7 zero write keeps");
    wr(5'h00, 2);  rd(5'h00, 1, "R7 other bit keeps");
    wr(5'h00, 1);  rd(5'h00, 0, "R7 one clears");
    chk("R8 irq1 after clear", {31'd0, irq_alarm1}, 0);

    wr(5'h14, 104);
    tsec();
    chk("R8 irq2 gated off", {31'd0, irq_alarm2}, 0);
    rd(5'h00, 2, "R5 alarm2 status");
    wr(5'h08, 1);
    chk("R8 irq2 enabled", {31'd0, irq_alarm2}, 1);
    wr(5'h00, 2);
    chk("R8 irq2 cleared", {31'd0, irq_alarm2}, 0);

    wr(5'h04, 2);
    tfast();
    rd(5'h00, 1, "R6 fast periodic");
    wr(5'h00, 1);
    wr(5'h04, 6);
    tfast();
    rd(5'h00, 0, "R6 fast ignored in 1Hz mode");
    tsec();
    rd(5'h00, 1, "R6 1Hz periodic");
    chk("R8 periodic no alarm enable", {31'd0, irq_alarm1}, 0);
    wr(5'h00, 1);
    wr(5'h04, 2);

    wait_ready();
    tick_fast = 1; wr(5'h00, 1); tick_fast = 0;
    rd(5'h00, 1, "R7 set beats clear");
    wr(5'h00, 1);
    rd(5'h00, 0, "R7 cleared after");

    wr(5'h18, 32'h55);
    n = 0;
    while (!bus_ready) begin n++; @(posedge clk); #1; end
    chk("R9 settle cycles", n, SETTLE);
    wr(5'h0C, 500);
    tsec();
    wr(5'h0C, 900);
    rd(5'h0C, 900, "R9 held write performed");
    rd(5'h18, 32'h55, "R9 calib kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule